// File: doc/BRIEF.md
# Priority-Threshold Vectored Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines and steers each one onto one of two processor interrupt outputs: a fast output and a normal output. Every line has its own polarity choice, a software request bit that raises the request without the hardware line, a 4-bit priority and a target bit. Masking does not use per-line enable bits. Each target keeps a 4-bit threshold, and a request reaches its target only when its priority is strictly above that threshold. Priority 0 therefore always masks a line.

For each target the block keeps a vector word. The word names the highest-priority qualifying line and gives that line's priority, so a handler finds its source with one read. A handler can nest by raising its target's threshold to the priority it is servicing, which lets only more urgent requests break in, and then restoring the threshold when it returns. All configuration and status goes through a simple synchronous register port: writes take effect at the clock edge and reads are combinational from the address. The outputs and vector words are registered and follow their inputs one clock later.

Top module: `irqr_top`

## Requirements
- R1: After reset both interrupt outputs are low, both vector words read 0, and every per-line config word and both thresholds read 0.
- R2: The per-line config word at address `i` (for `i` below the line count) holds the polarity in bit 0. With polarity 1 a low line is an active request; with polarity 0 a high line is active.
- R3: Bit 1 of the per-line config word is a software request. When it is 1 the line counts as active whatever level the hardware line has.
- R4: The status words at addresses 68 and 69 show the active state of each line after polarity and software request but before any priority masking. Line `i` appears in word `68 + i/32` at bit `i%32`.
- R5: A line whose priority field (config bits 6:3) is 0 never drives an output or a vector word, even while it is active.
- R6: Config bit 2 selects the target. 0 routes the line to the fast output and its vector word at address 66. 1 routes it to the normal output and its vector word at address 67.
- R7: Each target has a 4-bit threshold, at address 64 for the fast target and address 65 for the normal target. An active line qualifies for its target only when its priority is strictly greater than that threshold.
- R8: The vector word of a target is laid out as follows. Bit 15 is a valid flag, bits 13:8 hold the index of the qualifying line with the highest priority, and bits 3:0 hold that line's priority. A target's output is high exactly when its vector word is valid.
- R9: When several qualifying lines on one target share the highest priority, the line with the lowest index wins the vector word.
- R10: When no line qualifies for a target, that target's vector word reads all zeros and its output is low.
- R11: The outputs and vector words reflect the line levels and configuration of the previous clock cycle: a change becomes visible exactly one clock later.
- R12: Raising a target's threshold to the priority under service blocks requests of that priority or lower and lets higher ones through. Restoring the threshold brings back the earlier winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line_i | input | NUM_SRC (56) | Hardware request lines, synchronous to clk |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register address for reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| irq_fast_o | output | 1 | Fast-target interrupt output |
| irq_norm_o | output | 1 | Normal-target interrupt output |

## Verification
On every cycle, the assertions check the following against the state one cycle earlier. A valid vector always names a line that was active and routed to that target. The vector's priority matches that line's configured priority, is non-zero and is strictly above the target's threshold. An invalid vector has zero fields, and the two targets never name the same line. The assertions cannot tell whether the named line really was the best candidate. The bench's scenarios and its per-cycle reference model establish that the winner is the highest priority with the lowest index on ties, that polarity and software requests feed the pre-mask status, that the output changes exactly one clock after a write, and that nesting and restoring a threshold behave as intended.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int PRIO_W = 4;
  localparam int IDX_W  = 6;
  localparam int DATA_W = 32;
  localparam int CFG_W  = PRIO_W + 3;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              tgt;
    logic              sw;
    logic              pol;
  } src_cfg_t;

  typedef struct packed {
    logic              valid;
    logic [IDX_W-1:0]  idx;
    logic [PRIO_W-1:0] prio;
  } vec_t;

  // request qualifies for a target only above its threshold
  function automatic logic prio_passes(input logic [PRIO_W-1:0] p,
                                       input logic [PRIO_W-1:0] thr);
    return p > thr;
  endfunction

  // strict compare: an equal candidate never displaces the earlier index
  function automatic logic outranks(input logic [PRIO_W-1:0] cand,
                                    input logic [PRIO_W-1:0] best);
    return cand > best;
  endfunction

  function automatic logic [DATA_W-1:0] pack_vec(input vec_t v);
    logic [DATA_W-1:0] w;
    w = '0;
    w[15]                 = v.valid;
    w[8 +: IDX_W]         = v.idx;
    w[PRIO_W-1:0]         = v.prio;
    return w;
  endfunction
endpackage

// File: rtl/irqr_cfg_regs.sv
module irqr_cfg_regs
  import irqr_pkg::*;
#(
  parameter int NUM_SRC = 56,
  parameter int ADDR_W  = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output src_cfg_t             cfg_o [NUM_SRC],
  output logic [PRIO_W-1:0]    thr_o [2]
);
  localparam int THR_BASE = 2 ** IDX_W;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
      logic hit;
      assign hit = wr_en_i && (addr_i == ADDR_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cfg_o[gi] <= '0;
        else if (hit) cfg_o[gi] <= src_cfg_t'(wdata_i[CFG_W-1:0]);
      end
    end
    for (gi = 0; gi < 2; gi++) begin : g_thr
      logic hit;
      assign hit = wr_en_i && (addr_i == ADDR_W'(THR_BASE + gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   thr_o[gi] <= '0;
        else if (hit) thr_o[gi] <= wdata_i[PRIO_W-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/irqr_req_cond.sv
module irqr_req_cond
  import irqr_pkg::*;
#(
  parameter int NUM_SRC = 56
) (
  input  logic [NUM_SRC-1:0] line_i,
  input  src_cfg_t           cfg_i [NUM_SRC],
  output logic [NUM_SRC-1:0] raw_o
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_cond
      logic lvl_active;
      assign lvl_active = line_i[gi] ^ cfg_i[gi].pol;
      assign raw_o[gi]  = lvl_active | cfg_i[gi].sw;
    end
  endgenerate
endmodule

// File: rtl/irqr_arbiter.sv
module irqr_arbiter
  import irqr_pkg::*;
#(
  parameter int NUM_SRC = 56,
  parameter bit TGT     = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   raw_i,
  input  src_cfg_t             cfg_i [NUM_SRC],
  input  logic [PRIO_W-1:0]    thr_i,
  output vec_t                 vec_o
);
  vec_t best;

  always_comb begin
    best = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (raw_i[i] && (cfg_i[i].tgt == TGT) &&
          prio_passes(cfg_i[i].prio, thr_i) &&
          outranks(cfg_i[i].prio, best.prio)) begin
        best.valid = 1'b1;
        best.idx   = IDX_W'(i);
        best.prio  = cfg_i[i].prio;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_o <= '0;
    else        vec_o <= best;
  end

  // previous-cycle copies kept only for the checks below
  logic [NUM_SRC-1:0] raw_q;
  src_cfg_t           cfg_q [NUM_SRC];
  logic [PRIO_W-1:0]  thr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      thr_q <= '0;
      for (int i = 0; i < NUM_SRC; i++) cfg_q[i] <= '0;
    end else begin
      raw_q <= raw_i;
      thr_q <= thr_i;
      for (int i = 0; i < NUM_SRC; i++) cfg_q[i] <= cfg_i[i];
    end
  end

  p_thr_strict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_o.valid |-> (vec_o.prio > thr_q));
  p_prio_zero_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_o.valid |-> (vec_o.prio != '0));
  p_idx_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_o.valid |-> (int'(vec_o.idx) < NUM_SRC));
  p_winner_real_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_o.valid |-> (raw_q[vec_o.idx] && (cfg_q[vec_o.idx].tgt == TGT) &&
                     (cfg_q[vec_o.idx].prio == vec_o.prio)));
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_o.valid |-> (vec_o.idx == '0 && vec_o.prio == '0));
endmodule

// File: rtl/irqr_top.sv
module irqr_top
  import irqr_pkg::*;
#(
  parameter int NUM_SRC = 56,
  parameter int ADDR_W  = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  irq_line_i,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_fast_o,
  output logic                irq_norm_o
);
  localparam int THR_BASE   = 2 ** IDX_W;
  localparam int VEC_BASE   = THR_BASE + 2;
  localparam int STAT_BASE  = THR_BASE + 4;
  localparam int STAT_WORDS = (NUM_SRC + DATA_W - 1) / DATA_W;

  src_cfg_t           cfg   [NUM_SRC];
  logic [PRIO_W-1:0]  thr   [2];
  logic [NUM_SRC-1:0] raw;
  vec_t               vec   [2];

  irqr_cfg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .cfg_o(cfg), .thr_o(thr)
  );

  irqr_req_cond #(.NUM_SRC(NUM_SRC)) u_cond (
    .line_i(irq_line_i), .cfg_i(cfg), .raw_o(raw)
  );

  genvar gt;
  generate
    for (gt = 0; gt < 2; gt++) begin : g_tgt
      irqr_arbiter #(.NUM_SRC(NUM_SRC), .TGT(gt[0])) u_arb (
        .clk(clk), .rst_n(rst_n), .raw_i(raw), .cfg_i(cfg),
        .thr_i(thr[gt]), .vec_o(vec[gt])
      );
    end
  endgenerate

  assign irq_fast_o = vec[0].valid;
  assign irq_norm_o = vec[1].valid;

  logic [STAT_WORDS*DATA_W-1:0] raw_pad;
  assign raw_pad = {{(STAT_WORDS*DATA_W-NUM_SRC){1'b0}}, raw};

  always_comb begin
    int a;
    a = int'(reg_addr_i);
    reg_rdata_o = '0;
    if (a < NUM_SRC)
      reg_rdata_o[CFG_W-1:0] = cfg[reg_addr_i[IDX_W-1:0]];
    else if (a == THR_BASE || a == THR_BASE + 1)
      reg_rdata_o[PRIO_W-1:0] = thr[reg_addr_i[0]];
    else if (a == VEC_BASE || a == VEC_BASE + 1)
      reg_rdata_o = pack_vec(vec[reg_addr_i[0]]);
    else if (a >= STAT_BASE && a < STAT_BASE + STAT_WORDS)
      reg_rdata_o = raw_pad[(a - STAT_BASE)*DATA_W +: DATA_W];
  end

  p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec[0].valid && vec[1].valid) |-> (vec[0].idx != vec[1].idx));
endmodule

// File: tb/irqr_top_tb.sv
module irqr_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 56;
  localparam int WD_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] line = '0;
  logic          wr = 1'b0;
  logic [6:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq_fast, irq_norm;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqr_top u_dut (
    .clk(clk), .rst_n(rst_n), .irq_line_i(line), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_fast_o(irq_fast), .irq_norm_o(irq_norm)
  );

  int n_checks = 0, n_errors = 0;
  bit run = 0, done = 0;

  // behavioural reference state
  bit m_pol[NS], m_sw[NS], m_tgt[NS];
  int m_prio[NS];
  int m_thr[2];
  bit ev[2];
  int ei[2], ep[2];

  function automatic bit active(int i);
    return (line[i] ^ m_pol[i]) | m_sw[i];
  endfunction

  // search from the top priority downward, then by rising index
  function automatic void pick(int t, output bit v, output int idx, output int p);
    v = 0; idx = 0; p = 0;
    for (int pr = 15; pr > m_thr[t]; pr--) begin
      for (int i = 0; i < NS; i++) begin
        if (active(i) && m_tgt[i] == t[0] && m_prio[i] == pr) begin
          v = 1; idx = i; p = pr; return;
        end
      end
    end
  endfunction

  function automatic logic [31:0] model_read(int a);
    logic [31:0] w;
    w = '0;
    if (a < NS) w = (m_prio[a] << 3) | (m_tgt[a] << 2) | (m_sw[a] << 1) | m_pol[a];
    else if (a == 64 || a == 65) w = m_thr[a-64];
    else if (a == 66 || a == 67) w = (ev[a-66] << 15) | (ei[a-66] << 8) | ep[a-66];
    else if (a == 68 || a == 69)
      for (int b = 0; b < 32; b++)
        if ((a-68)*32 + b < NS) w[b] = active((a-68)*32 + b);
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        m_pol[i] = 0; m_sw[i] = 0; m_tgt[i] = 0; m_prio[i] = 0;
      end
      m_thr[0] = 0; m_thr[1] = 0;
      for (int t = 0; t < 2; t++) begin ev[t] = 0; ei[t] = 0; ep[t] = 0; end
    end else begin
      for (int t = 0; t < 2; t++) pick(t, ev[t], ei[t], ep[t]);
      if (wr) begin
        if (int'(addr) < NS) begin
          m_pol[addr] = wdata[0]; m_sw[addr] = wdata[1];
          m_tgt[addr] = wdata[2]; m_prio[addr] = int'(wdata[6:3]);
        end else if (addr == 7'd64 || addr == 7'd65) begin
          m_thr[addr-64] = int'(wdata[3:0]);
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every cycle: outputs against the model (R11 latency, R8 output = valid)
  always @(negedge clk) begin
    if (run && rst_n) begin
      chk("R11 irq_fast per-cycle", {31'b0, irq_fast}, {31'b0, ev[0]});
      chk("R11 irq_norm per-cycle", {31'b0, irq_norm}, {31'b0, ev[1]});
    end
  end

  task automatic wr_reg(int a, logic [31:0] d);
    @(negedge clk); wr = 1; addr = 7'(a); wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_lit(string tag, int a, logic [31:0] exp);
    addr = 7'(a); #1;
    chk(tag, rdata, exp);
    chk({tag, " model"}, rdata, model_read(a));
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cw(int p, int t, int s, int pl);
    return 32'((p << 3) | (t << 2) | (s << 1) | pl);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    run = 1;
    step(1);
    // R1 reset state
    chk("R1 irq_fast reset", {31'b0, irq_fast}, 32'd0);
    chk("R1 irq_norm reset", {31'b0, irq_norm}, 32'd0);
    rd_lit("R1 vec fast reset", 66, 32'h0);
    rd_lit("R1 vec norm reset", 67, 32'h0);
    rd_lit("R1 cfg reset", 5, 32'h0);
    rd_lit("R1 thr reset", 64, 32'h0);

    // R11: one clock of latency after a config write
    line[5] = 1;
    wr_reg(5, cw(3, 0, 0, 0));
    chk("R11 not yet", {31'b0, irq_fast}, 32'd0);
    step(1);
    chk("R11 one clock later", {31'b0, irq_fast}, 32'd1);
    rd_lit("R8 vec fast src5", 66, 32'h0000_8503);

    // R2 polarity, R6 normal target
    line[10] = 0;
    wr_reg(10, cw(2, 1, 0, 1));
    step(1);
    rd_lit("R4 status low-active src10", 68, 32'h0000_0420);
    chk("R6 irq_norm on", {31'b0, irq_norm}, 32'd1);
    rd_lit("R6 vec norm src10", 67, 32'h0000_8A02);
    line[10] = 1;
    step(2);
    chk("R2 high line inactive with pol=1", {31'b0, irq_norm}, 32'd0);

    // R3 software request on src40 (status word 69 bit 8)
    wr_reg(40, cw(4, 1, 1, 0));
    step(1);
    rd_lit("R3 status sw src40", 69, 32'h0000_0100);
    rd_lit("R3 vec norm src40", 67, 32'h0000_A804);

    // R5 priority 0 masked
    line[5] = 0; line[20] = 1;
    step(2);
    rd_lit("R4 status src20 pre-mask", 68, 32'h0010_0000);
    chk("R5 prio0 no irq", {31'b0, irq_fast}, 32'd0);
    rd_lit("R5 vec fast empty", 66, 32'h0);

    // R7 strict threshold
    line[5] = 1;
    wr_reg(64, 3);
    step(1);
    chk("R7 prio equal to thr blocked", {31'b0, irq_fast}, 32'd0);
    wr_reg(64, 2);
    step(1);
    chk("R7 prio above thr passes", {31'b0, irq_fast}, 32'd1);

    // R9 tie, R8 highest
    line[12] = 1; line[30] = 1;
    wr_reg(30, cw(7, 0, 0, 0));
    wr_reg(12, cw(7, 0, 0, 0));
    step(1);
    rd_lit("R9 tie lowest index", 66, 32'h0000_8C07);
    wr_reg(30, cw(9, 0, 0, 0));
    step(1);
    rd_lit("R8 highest priority wins", 66, 32'h0000_9E09);

    // R12 nesting
    wr_reg(64, 9);
    step(1);
    chk("R12 nested blocks same prio", {31'b0, irq_fast}, 32'd0);
    wr_reg(45, cw(11, 0, 1, 0));
    step(1);
    chk("R12 higher breaks in", {31'b0, irq_fast}, 32'd1);
    rd_lit("R12 vec nested", 66, 32'h0000_AD0B);
    wr_reg(45, 32'h0);
    wr_reg(64, 2);
    step(1);
    rd_lit("R12 restored winner", 66, 32'h0000_9E09);

    // R10 nothing qualifies on normal target
    wr_reg(65, 15);
    step(1);
    chk("R10 irq_norm off", {31'b0, irq_norm}, 32'd0);
    rd_lit("R10 vec norm zero", 67, 32'h0);
    rd_lit("R7 thr readback", 65, 32'h0000_000F);

    // sweep every address against the model (R4, R8)
    for (int a = 0; a < 72; a++) begin
      addr = 7'(a); #1;
      chk("R4 R8 register sweep", rdata, model_read(a));
    end
    step(2);
    finish_run();
  end
endmodule